// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two packed single-precision values, a left operand `op_d` and a right operand `op_m`, and reports the outcome as a four-bit condition code plus a separate invalid-operation flag. It does not unpack the operands into sign, exponent and significand. Ordered results come from an unsigned integer compare of the raw words, corrected by the sign bit. NaN detection looks only at the exponent and fraction fields.

Two control inputs shape the operation. `sig_qnan` makes quiet NaNs raise invalid as well as signalling ones. `vs_zero` discards `op_m` and compares against positive zero. By default the result is held in an output register, so it appears one clock after the inputs. With `REG_OUT = 0` the path is purely combinational.

Top module: `fcmp_flags`

## Requirements
- R1: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. If either operand is a NaN, `flags` = 4'b0011, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R2: `invalid` is 1 when either operand is a NaN whose top fraction bit (bit 22) is 0, which marks a signalling NaN.
- R3: While `sig_qnan` is 1, any NaN operand, quiet ones included, sets `invalid`. While it is 0, a quiet NaN leaves `invalid` at 0.
- R4: When neither operand is a NaN, `invalid` is 0, whatever the value of `sig_qnan`.
- R5: Two operands compare equal when their bit patterns are identical or when both have a zero magnitude (+0 and -0). Equal gives `flags` = 4'b0110.
- R6: When the signs differ and the values are not equal, a negative `op_d` gives less-than (`flags` = 4'b1000) and a positive `op_d` gives greater-than (`flags` = 4'b0010).
- R7: When the signs match, `op_d` is less than `op_m` exactly when (sign bit) XOR (`op_d` < `op_m` as unsigned 32-bit integers) is 1. The rule covers denormals and negative values.
- R8: While `vs_zero` is 1, `op_m` has no effect and the comparison uses +0 (all bits zero) as the right operand.
- R9: Infinities (exponent all ones, fraction zero) are ordered values, not NaNs. Two equal infinities compare equal, and +infinity is greater than the largest finite value.
- R10: With `REG_OUT` = 1, `flags` and `invalid` change one rising clock edge after the inputs change. An active-low `rst_n` clears them asynchronously to 4'b0000 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_d | input | 32 | Left operand, packed single precision |
| op_m | input | 32 | Right operand, packed single precision |
| sig_qnan | input | 1 | Quiet NaNs also raise invalid |
| vs_zero | input | 1 | Replace the right operand with +0 |
| flags | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The bench targets the places where a raw-bit compare goes wrong.

- **Signed zeros.** A design that compared only bit patterns would call +0 and -0 unequal.
- **Negative operands.** A design that skipped the sign correction would order them backwards.
- **Infinities versus NaNs.** A design that tested only the exponent would turn infinities into unordered results.
- **Quiet versus signalling NaNs.** These are checked with `sig_qnan` both clear and set, since a wrong polarity on the quiet bit flips `invalid`.
- **Compare-with-zero.** This is driven with a signalling NaN on `op_m`, so a design that still read `op_m` would report an unordered, invalid result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Condition code encoding {N,Z,C,V}
    localparam logic [3:0] FLAGS_LT = 4'b1000;
    localparam logic [3:0] FLAGS_EQ = 4'b0110;
    localparam logic [3:0] FLAGS_GT = 4'b0010;
    localparam logic [3:0] FLAGS_UN = 4'b0011;

    typedef struct packed {
        logic [3:0] flags;
        logic       invalid;
    } cmp_res_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output logic                  is_nan_o,
    output logic                  is_quiet_o,
    output logic                  mag_zero_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f      = word_i[W-2:FRAC_W];
    assign frac_f     = word_i[FRAC_W-1:0];
    assign is_nan_o   = (&exp_f) && (|frac_f);
    assign is_quiet_o = frac_f[FRAC_W-1];
    assign mag_zero_o = ~|word_i[W-2:0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] m_i,
    input  logic         d_zero_i,
    input  logic         m_zero_i,
    output logic         lt_o,
    output logic         eq_o
);
    logic sign_diff;
    logic ult;

    assign sign_diff = d_i[W-1] ^ m_i[W-1];
    assign ult       = d_i < m_i;
    assign eq_o      = (d_i == m_i) || (d_zero_i && m_zero_i);

    always_comb begin
        if (sign_diff) lt_o = d_i[W-1];
        else           lt_o = d_i[W-1] ^ ult;
    end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_d,
    input  logic [EXP_W+FRAC_W:0] op_m,
    input  logic                  sig_qnan,
    input  logic                  vs_zero,
    output logic [3:0]            flags,
    output logic                  invalid
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int N_OPS = 2;

    logic [W-1:0]     opnd [N_OPS];
    logic [N_OPS-1:0] nan_v;
    logic [N_OPS-1:0] quiet_v;
    logic [N_OPS-1:0] zero_v;
    logic             lt;
    logic             eq;
    cmp_res_t         res_d;
    cmp_res_t         res_q;

    assign opnd[0] = op_d;
    assign opnd[1] = vs_zero ? '0 : op_m;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word_i     (opnd[i]),
            .is_nan_o   (nan_v[i]),
            .is_quiet_o (quiet_v[i]),
            .mag_zero_o (zero_v[i])
        );
    end

    fcmp_order #(.W(W)) u_ord (
        .d_i      (opnd[0]),
        .m_i      (opnd[1]),
        .d_zero_i (zero_v[0]),
        .m_zero_i (zero_v[1]),
        .lt_o     (lt),
        .eq_o     (eq)
    );

    always_comb begin
        res_d = '0;
        if (|nan_v) begin
            res_d.flags   = FLAGS_UN;
            res_d.invalid = |(nan_v & (~quiet_v | {N_OPS{sig_qnan}}));
        end else if (eq) begin
            res_d.flags = FLAGS_EQ;
        end else if (lt) begin
            res_d.flags = FLAGS_LT;
        end else begin
            res_d.flags = FLAGS_GT;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign flags   = res_q.flags;
    assign invalid = res_q.invalid;
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EXP_W+FRAC_W:0] op_d,
    input logic [EXP_W+FRAC_W:0] op_m,
    input logic                  sig_qnan,
    input logic                  vs_zero,
    input logic [3:0]            flags,
    input logic                  invalid
);
    localparam int W = 1 + EXP_W + FRAC_W;

    function automatic logic word_nan(input logic [W-1:0] w);
        return (&w[W-2:FRAC_W]) && (|w[FRAC_W-1:0]);
    endfunction

    function automatic logic word_snan(input logic [W-1:0] w);
        return word_nan(w) && !w[FRAC_W-1];
    endfunction

    logic         primed;
    logic [W-1:0] d_p;
    logic [W-1:0] m_p;
    logic         z_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed <= 1'b0;
            d_p    <= '0;
            m_p    <= '0;
            z_p    <= 1'b0;
        end else begin
            primed <= 1'b1;
            d_p    <= op_d;
            m_p    <= vs_zero ? '0 : op_m;
            z_p    <= vs_zero;
        end
    end

    if (REG_OUT) begin : g_props
        // R1
        nan_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed && (word_nan(d_p) || word_nan(m_p)) |-> flags == 4'b0011);
        // R2
        snan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed && (word_snan(d_p) || word_snan(m_p)) |-> invalid);
        // R4
        ordered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed && !word_nan(d_p) && !word_nan(m_p) |-> !invalid);
        // R5
        same_bits_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed && !word_nan(d_p) && (d_p == m_p) |-> flags == 4'b0110);
        // R8
        zero_vs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed && z_p && (d_p[W-2:0] == '0) |-> flags == 4'b0110);
        // R10
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (flags == 4'b0000) && !invalid);
    end
endmodule

bind fcmp_flags fcmp_flags_chk #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_d(op_d), .op_m(op_m),
    .sig_qnan(sig_qnan), .vs_zero(vs_zero), .flags(flags), .invalid(invalid)
);

// File: tb/sim_fcmp_flags.sv
module sim_fcmp_flags;

    typedef struct packed {
        logic [31:0] d;
        logic [31:0] m;
        logic        sq;
        logic        z;
        logic [3:0]  f;
        logic        inv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h7fc00000, 32'h3f800000, 1'b0, 1'b0, 4'b0011, 1'b0, 4'd1},  // R1 quiet NaN d
        '{32'h3f800000, 32'h7f800001, 1'b0, 1'b0, 4'b0011, 1'b1, 4'd2},  // R2 signalling NaN m
        '{32'h7fc00000, 32'h00000000, 1'b1, 1'b0, 4'b0011, 1'b1, 4'd3},  // R3 quiet NaN with sig_qnan
        '{32'h7fc00000, 32'h7fc00001, 1'b0, 1'b0, 4'b0011, 1'b0, 4'd3},  // R3 two quiet NaNs, no signal
        '{32'h3f800000, 32'h40000000, 1'b1, 1'b0, 4'b1000, 1'b0, 4'd4},  // R4 ordered, sig_qnan set
        '{32'h00000000, 32'h80000000, 1'b0, 1'b0, 4'b0110, 1'b0, 4'd5},  // R5 +0 vs -0
        '{32'h40490fdb, 32'h40490fdb, 1'b0, 1'b0, 4'b0110, 1'b0, 4'd5},  // R5 identical
        '{32'hbf800000, 32'h3f800000, 1'b0, 1'b0, 4'b1000, 1'b0, 4'd6},  // R6 d negative
        '{32'h3f800000, 32'hc0000000, 1'b0, 1'b0, 4'b0010, 1'b0, 4'd6},  // R6 d positive
        '{32'h80000000, 32'h00000001, 1'b0, 1'b0, 4'b1000, 1'b0, 4'd6},  // R6 -0 vs +denormal
        '{32'h40000000, 32'h3f800000, 1'b0, 1'b0, 4'b0010, 1'b0, 4'd7},  // R7 2 > 1
        '{32'hc0000000, 32'hbf800000, 1'b0, 1'b0, 4'b1000, 1'b0, 4'd7},  // R7 -2 < -1
        '{32'hbf800000, 32'hc0000000, 1'b0, 1'b0, 4'b0010, 1'b0, 4'd7},  // R7 -1 > -2
        '{32'h00000001, 32'h00000002, 1'b0, 1'b0, 4'b1000, 1'b0, 4'd7},  // R7 denormals
        '{32'h7f800000, 32'h7f7fffff, 1'b0, 1'b0, 4'b0010, 1'b0, 4'd9},  // R9 +inf > max
        '{32'hff800000, 32'hff800000, 1'b0, 1'b0, 4'b0110, 1'b0, 4'd9},  // R9 -inf == -inf
        '{32'hff800000, 32'h7f800000, 1'b1, 1'b0, 4'b1000, 1'b0, 4'd9},  // R9 -inf < +inf
        '{32'h3f800000, 32'h7f800001, 1'b0, 1'b1, 4'b0010, 1'b0, 4'd8},  // R8 m ignored
        '{32'h80000000, 32'hffffffff, 1'b0, 1'b1, 4'b0110, 1'b0, 4'd8},  // R8 -0 vs +0
        '{32'hbf800000, 32'h3f800000, 1'b0, 1'b1, 4'b1000, 1'b0, 4'd8},  // R8 negative vs +0
        '{32'h7fa00000, 32'h00000000, 1'b0, 1'b1, 4'b0011, 1'b1, 4'd8}   // R8 sNaN d vs +0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_d = '0;
    logic [31:0] op_m = '0;
    logic        sig_qnan = 1'b0;
    logic        vs_zero = 1'b0;
    logic [3:0]  flags;
    logic        invalid;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fcmp_flags u0 (
        .clk(clk), .rst_n(rst_n), .op_d(op_d), .op_m(op_m),
        .sig_qnan(sig_qnan), .vs_zero(vs_zero), .flags(flags), .invalid(invalid)
    );

    task automatic check(input string tag, input logic [3:0] ef, input logic ei);
        checks++;
        if (flags !== ef || invalid !== ei) begin
            errors++;
            $display("FAIL %s: flags=%b invalid=%b expected flags=%b invalid=%b",
                     tag, flags, invalid, ef, ei);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        op_d = v.d; op_m = v.m; sig_qnan = v.sq; vs_zero = v.z;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", 4'b0000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].f, VECS[i].inv);
        end

        // R10 latency: new inputs are not visible before the next rising edge
        apply('{32'h3f800000, 32'h40000000, 1'b0, 1'b0, 4'b1000, 1'b0, 4'd10});
        op_d = 32'h40000000; op_m = 32'h3f800000;
        #1 check("R10 held before edge", 4'b1000, 1'b0);
        @(negedge clk);
        check("R10 updated after edge", 4'b0010, 1'b0);

        // R2 signalling NaN in d, quiet in m, no sig_qnan
        apply('{32'hff800123, 32'h7fc00000, 1'b0, 1'b0, 4'b0011, 1'b1, 4'd2});
        check("R2 snan d with qnan m", 4'b0011, 1'b1);

        // R10 asynchronous reset mid-run
        apply('{32'h7f800001, 32'h0, 1'b0, 1'b0, 4'b0011, 1'b1, 4'd10});
        #1 rst_n = 1'b0;
        #1 check("R10 async clear", 4'b0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule